// File: doc/BRIEF.md
# Read Termination Window Timer

This block drives the on-die termination control of one byte lane of a DDR memory interface while read data returns. Its clock runs at twice the memory clock, so each clock cycle is one half memory cycle, and every delay in the block is counted in those half-cycle steps. The controller pulses `rd_cmd_i` on the reference beat of each read, which is the point four beats before the end of the read command. That pulse starts a local count, and termination is switched on and off at the programmed offsets from it.

A 32-bit configuration word sets the on and off offsets, the level that means "terminated" on the output pin, and whether termination follows reads or is held at a fixed level. The same count also produces two single-cycle marks that open and close the DQS sampling window. Each mark can be pushed one half cycle later by one bit of its own field. Several test bits in the word have no function in normal use and are ignored.

Configuration word layout: bits 31:28 turn-on offset, bits 27:24 turn-off offset, bit 23 active output level, bit 22 dynamic enable, bit 15 static-disable select, bit 8 close-mark delay (the only live bit of field 11:8), bit 0 open-mark delay (the only live bit of field 7:0). All other bits are ignored.

Top module: `rd_term_timer`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first read, `odt_o` sits at the inactive level (the inverse of cfg bit 23) and both marks are low.
- R2: In dynamic mode (bit 22 = 1), with turn-on offset ON and turn-off offset OFF, a read pulse sampled at clock edge k makes termination active after edges k+ON through k+OFF-1, which is OFF-ON cycles in total.
- R3: If OFF is less than or equal to ON, a read produces no active cycle at all.
- R4: A read that arrives while termination is active keeps it active without a gap until OFF cycles after the new read.
- R5: `odt_o` equals cfg bit 23 when termination is active and its inverse when inactive.
- R6: In static mode (bit 22 = 0), termination is active from the next edge on when bit 15 is 0 and never active when bit 15 is 1, and read pulses have no effect on it.
- R7: `dqs_open_o` is high for exactly one cycle, after edge k+OPEN_BASE+cfg[0].
- R8: `dqs_close_o` is high for exactly one cycle, after edge k+CLOSE_BASE+cfg[8].
- R9: Bits 21:16, 14:12, 11:9 and 7:1 have no effect on any output.
- R10: A read that arrives while termination is still inactive restarts all timing (window and marks) from the new read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the memory clock rate; one cycle is a half memory cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_cmd_i | input | 1 | One-cycle pulse on the reference beat of a read |
| cfg_i | input | 32 | Configuration word |
| odt_o | output | 1 | Termination control to the pad |
| dqs_open_o | output | 1 | One-cycle mark that opens the DQS sampling window |
| dqs_close_o | output | 1 | One-cycle mark that closes the DQS sampling window |

## Verification
The bench targets empty windows, where OFF equals ON or is below it. A wrong comparison there would leak a pulse, or one that wraps around, into the pad. It sends a second read into an already open window to catch a design that restarts and drops termination for ON cycles. It also sends a second read before the window opens, where a design that extends instead of restarting would switch on early and give two open marks. It sets the test bits and the unused bits of the delay fields to ones, which exposes a delay decoded from the wrong bit. It toggles the polarity and static select bits, including during reset, which exposes a reset state that ignores polarity.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
   localparam int DLY_W   = 4;
   localparam int CFG_W   = 32;
   localparam int ON_LSB  = 28;
   localparam int OFF_LSB = 24;
   localparam int POL_BIT = 23;
   localparam int DYN_BIT = 22;
   localparam int SEL_BIT = 15;
   localparam int SD1_BIT = 8;
   localparam int SD0_BIT = 0;

   typedef struct packed {
      logic [DLY_W-1:0] on_dly;
      logic [DLY_W-1:0] off_dly;
      logic             act_high;
      logic             dynamic;
      logic             static_off;
      logic             open_late;
      logic             close_late;
   } rdt_cfg_t;
endpackage

// File: rtl/rdt_cfg_decode.sv
module rdt_cfg_decode
   import rdt_pkg::*;
(
   input  logic [CFG_W-1:0] word_i,
   output rdt_cfg_t         cfg_o
);
   // Test and don't-care bits are gathered here only to mark them as deliberately unused.
   logic unused_bits;
   assign unused_bits = ^{word_i[21:16], word_i[14:12], word_i[11:9], word_i[7:1]};

   always_comb begin
      cfg_o.on_dly     = word_i[ON_LSB  +: DLY_W];
      cfg_o.off_dly    = word_i[OFF_LSB +: DLY_W];
      cfg_o.act_high   = word_i[POL_BIT];
      cfg_o.dynamic    = word_i[DYN_BIT];
      cfg_o.static_off = word_i[SEL_BIT];
      cfg_o.open_late  = word_i[SD0_BIT];
      cfg_o.close_late = word_i[SD1_BIT];
   end
endmodule

// File: rtl/rdt_ref_counter.sv
module rdt_ref_counter #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic [CNT_W-1:0] cnt_nxt_o
);
   localparam logic [CNT_W-1:0] MAXV = '1;

   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      if (start_i)            cnt_nxt_o = '0;
      else if (cnt_q == MAXV) cnt_nxt_o = cnt_q;
      else                    cnt_nxt_o = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= MAXV;
      else        cnt_q <= cnt_nxt_o;
   end
endmodule

// File: rtl/rdt_term_window.sv
module rdt_term_window
   import rdt_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] cnt_nxt_i,
   input  rdt_cfg_t         cfg_i,
   output logic             term_o
);
   logic [CNT_W-1:0] on_w, off_w;
   logic             win_ok, ext_q, ext_nxt, in_win, term_d, term_q;

   assign on_w    = CNT_W'(cfg_i.on_dly);
   assign off_w   = CNT_W'(cfg_i.off_dly);
   assign win_ok  = off_w > on_w;
   assign ext_nxt = start_i ? term_q : ext_q;
   assign in_win  = win_ok && (cnt_nxt_i < off_w) && ((cnt_nxt_i >= on_w) || ext_nxt);
   assign term_d  = cfg_i.dynamic ? in_win : ~cfg_i.static_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q  <= 1'b0;
         term_q <= 1'b0;
      end else begin
         ext_q  <= ext_nxt;
         term_q <= term_d;
      end
   end

   assign term_o = term_q;

   p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i.dynamic && start_i && cfg_i.on_dly == '0 && cfg_i.off_dly != '0) |=> term_q);
   p_empty_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i.dynamic && (cfg_i.off_dly <= cfg_i.on_dly)) |=> !term_q);
   p_bridge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i.dynamic && (cfg_i.off_dly > cfg_i.on_dly) && start_i && term_q) |=> term_q);
   p_static_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_i.dynamic && !cfg_i.static_off) |=> term_q);
   p_static_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_i.dynamic && cfg_i.static_off) |=> !term_q);
endmodule

// File: rtl/rdt_mark_pulse.sv
module rdt_mark_pulse #(
   parameter int CNT_W = 4,
   parameter int BASE  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_nxt_i,
   input  logic             late_i,
   output logic             pulse_o
);
   localparam logic [CNT_W-1:0] MAXV = '1;
   localparam logic [CNT_W-1:0] T0   = CNT_W'(BASE);
   localparam logic [CNT_W-1:0] T1   = CNT_W'(BASE + 1);

   logic [CNT_W-1:0] target;
   logic             pulse_q;

   assign target = late_i ? T1 : T0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= (cnt_nxt_i == target);
   end

   assign pulse_o = pulse_q;

   // R7 / R8: once the count has run out, the mark stays quiet.
   p_sat_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_nxt_i == MAXV) |=> !pulse_q);
endmodule

// File: rtl/rd_term_timer.sv
module rd_term_timer
   import rdt_pkg::*;
#(
   parameter int CNT_W      = 4,
   parameter int OPEN_BASE  = 3,
   parameter int CLOSE_BASE = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_cmd_i,
   input  logic [CFG_W-1:0] cfg_i,
   output logic             odt_o,
   output logic             dqs_open_o,
   output logic             dqs_close_o
);
   localparam int NMARK = 2;
   localparam int LAST  = (1 << CNT_W) - 1;
   localparam int BASES [NMARK] = '{OPEN_BASE, CLOSE_BASE};

   if (CNT_W < DLY_W)               $error("CNT_W must cover the delay fields");
   if (OPEN_BASE < 1)               $error("OPEN_BASE must be at least 1");
   if (OPEN_BASE + 1 >= LAST)       $error("OPEN_BASE does not fit the counter");
   if (CLOSE_BASE + 1 >= LAST)      $error("CLOSE_BASE does not fit the counter");

   rdt_cfg_t         cfg;
   logic [CNT_W-1:0] cnt_nxt;
   logic             term_en;
   logic [NMARK-1:0] late, marks;

   rdt_cfg_decode u_dec (.word_i(cfg_i), .cfg_o(cfg));

   rdt_ref_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .start_i(rd_cmd_i), .cnt_nxt_o(cnt_nxt));

   rdt_term_window #(.CNT_W(CNT_W)) u_win (
      .clk(clk), .rst_n(rst_n), .start_i(rd_cmd_i), .cnt_nxt_i(cnt_nxt),
      .cfg_i(cfg), .term_o(term_en));

   assign late = {cfg.close_late, cfg.open_late};

   for (genvar g = 0; g < NMARK; g++) begin : g_mark
      rdt_mark_pulse #(.CNT_W(CNT_W), .BASE(BASES[g])) u_mark (
         .clk(clk), .rst_n(rst_n), .cnt_nxt_i(cnt_nxt),
         .late_i(late[g]), .pulse_o(marks[g]));
   end

   assign odt_o       = term_en ? cfg.act_high : ~cfg.act_high;
   assign dqs_open_o  = marks[0];
   assign dqs_close_o = marks[1];
endmodule

// File: tb/rd_term_timer_tb.sv
module rd_term_timer_tb;
   localparam int NS = 20;

   typedef struct packed {
      logic [31:0] cfg;
      logic [4:0]  first;
      logic [4:0]  len;
      logic [4:0]  opn;
      logic [4:0]  cls;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{32'h26C0_0000, 5'd2, 5'd4,  5'd3, 5'd9},   // R2 basic
      '{32'h01C0_0101, 5'd0, 5'd1,  5'd4, 5'd10},  // R2 zero on, R7/R8 late
      '{32'h55C0_0000, 5'd0, 5'd0,  5'd3, 5'd9},   // R3 equal
      '{32'h93C0_0000, 5'd0, 5'd0,  5'd3, 5'd9},   // R3 reversed
      '{32'h1F7F_7EFE, 5'd1, 5'd14, 5'd3, 5'd9},   // R9 junk bits, R5 low active
      '{32'h7840_0FFF, 5'd7, 5'd1,  5'd4, 5'd10},  // R5 low active, R7/R8 late
      '{32'h0FE0_8000, 5'd0, 5'd15, 5'd3, 5'd9}    // R9 sel/test ignored in dynamic
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_cmd = 1'b0;
   logic [31:0] cfg = 32'h26C0_0000;
   logic        odt, dopen, dclose;
   int          errors = 0;
   int          checks = 0;

   always #5 clk = ~clk;

   rd_term_timer u_dut (
      .clk(clk), .rst_n(rst_n), .rd_cmd_i(rd_cmd), .cfg_i(cfg),
      .odt_o(odt), .dqs_open_o(dopen), .dqs_close_o(dclose));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Issue a read, optionally a second one after sample j == second, and record NS samples.
   task automatic run(input int second, output logic [NS-1:0] t, output logic [NS-1:0] o,
                      output logic [NS-1:0] c);
      t = '0; o = '0; c = '0;
      @(negedge clk); rd_cmd = 1'b1;
      @(negedge clk); rd_cmd = 1'b0;
      for (int j = 0; j < NS; j++) begin
         if (j > 0) @(negedge clk);
         rd_cmd = 1'b0;
         t[j] = (odt == cfg[23]);
         o[j] = dopen;
         c[j] = dclose;
         if (j == second) rd_cmd = 1'b1;
      end
   endtask

   function automatic logic [NS-1:0] span(input int first, input int len);
      logic [NS-1:0] m = '0;
      for (int j = 0; j < NS; j++) if (j >= first && j < first + len) m[j] = 1'b1;
      return m;
   endfunction

   initial begin
      #2_000_000;
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      summary();
   end

   initial begin
      logic [NS-1:0] t, o, c;
      // R1: reset level follows polarity
      idle(3);
      chk(odt == 1'b0, "R1 reset pol=1", {31'b0, odt}, 32'h0);
      chk({dopen, dclose} == 2'b00, "R1 marks in reset", {30'b0, dopen, dclose}, 32'h0);
      cfg = 32'h2640_0000;
      idle(1);
      chk(odt == 1'b1, "R1 reset pol=0", {31'b0, odt}, 32'h1);
      cfg = 32'h26C0_0000;
      rst_n = 1'b1;
      idle(4);
      chk(odt == 1'b0, "R1 idle after reset", {31'b0, odt}, 32'h0);
      chk({dopen, dclose} == 2'b00, "R1 marks idle", {30'b0, dopen, dclose}, 32'h0);

      // Vector table: R2, R3, R5, R7, R8, R9
      for (int v = 0; v < NV; v++) begin
         cfg = VECS[v].cfg;
         idle(18);
         chk(odt == ~cfg[23], "R5 idle level", {31'b0, odt}, {31'b0, ~cfg[23]});
         run(-1, t, o, c);
         chk(t == span(int'(VECS[v].first), int'(VECS[v].len)), "R2/R3 window",
             32'(t), 32'(span(int'(VECS[v].first), int'(VECS[v].len))));
         chk(o == span(int'(VECS[v].opn), 1), "R7 open mark", 32'(o), 32'(span(int'(VECS[v].opn), 1)));
         chk(c == span(int'(VECS[v].cls), 1), "R8 close mark", 32'(c), 32'(span(int'(VECS[v].cls), 1)));
      end

      // R4: second read at edge k+4 while active (on=2, off=6) -> on j=2..9
      cfg = 32'h26C0_0000;
      idle(18);
      run(3, t, o, c);
      chk(t == span(2, 8), "R4 back-to-back extension", 32'(t), 32'(span(2, 8)));

      // R10: second read at edge k+2 before window (on=4, off=6) -> on j=6,7; one open mark at j=5
      cfg = 32'h46C0_0000;
      idle(18);
      run(1, t, o, c);
      chk(t == span(6, 2), "R10 restart window", 32'(t), 32'(span(6, 2)));
      chk(o == span(5, 1), "R10 restart open mark", 32'(o), 32'(span(5, 1)));
      chk(c == span(11, 1), "R10 restart close mark", 32'(c), 32'(span(11, 1)));

      // R6: static on, reads ignored
      cfg = 32'h2680_0000;
      idle(2);
      run(-1, t, o, c);
      chk(t == '1, "R6 static on", 32'(t), 32'(NS'('1)));
      // R6: static off
      cfg = 32'h2680_8000;
      idle(2);
      run(-1, t, o, c);
      chk(t == '0, "R6 static off", 32'(t), 32'h0);
      chk(odt == 1'b0, "R6/R5 static off level", {31'b0, odt}, 32'h0);
      // R6 + R5: static on with low active level
      cfg = 32'h2600_0000;
      idle(2);
      chk(odt == 1'b0, "R5 static on low level", {31'b0, odt}, 32'h0);

      summary();
   end
endmodule